// File: doc/BRIEF.md
# Conversion Frame Reader for a Two-Channel Serial ADC

This block is a host-side serial master that pulls one conversion frame out of a two-channel, 16-bit delta-sigma converter each time the converter signals new data. It watches an active-low data-ready line. When that line falls, the block pulls chip select low and runs the serial clock long enough to bring in a 24-bit status word and then one 16-bit twos-complement word per channel, most significant bit first. After the last clock it keeps chip select low for a fixed guard time, then releases it. The status word and both samples then appear together on parallel outputs, with a single-cycle valid strobe.

Two retrieval modes are selected per frame by a level input. In continuous mode the frame bits are clocked straight out. In on-demand mode a read opcode byte is first sent on the data-in line, and the frame follows. A data-ready edge that arrives while a frame is still being read does not disturb that frame. Instead it sets a sticky overrun flag.

Top module: `adc_frame_reader`

## Requirements
- R1: While rst_ni is low and right after it: cs_no = 1, sclk_o = 0, mosi_o = 0, valid_o = 0, overrun_o = 0.
- R2: A high-to-low transition of drdy_ni, after a two-stage synchronizer, starts a frame by driving cs_no low. Holding drdy_ni low starts only that one frame. A low-to-high transition starts nothing.
- R3: In continuous mode (demand_i = 0 when the frame starts), exactly 56 SCLK pulses are issued. SCLK idles low, and cs_no stays low from the start of the frame until the guard time has ended.
- R4: miso_i is sampled on each falling SCLK edge of the frame portion. The first 24 bits, MSB first, form status_o[23:0]. The next 16 bits form channel 1 in ch_data_o[31:16], and the last 16 bits form channel 2 in ch_data_o[15:0].
- R5: In on-demand mode (demand_i = 1 when the frame starts), the opcode RD_OPCODE (default 8'h12) is sent MSB first on mosi_o during the first 8 SCLK pulses. Each opcode bit is stable while SCLK is high. The 56 frame pulses follow, for 64 pulses in total.
- R6: mosi_o is 0 at all times other than the opcode bits of an on-demand frame.
- R7: cs_no rises exactly GUARD_CYCLES system clocks (default 10) after the final falling SCLK edge of the frame.
- R8: valid_o is high for exactly one system clock: the first clock in which cs_no is high again. status_o and ch_data_o update at that moment and hold until the next frame completes.
- R9: A falling edge of drdy_ni while a frame is in progress (chip select low) sets overrun_o, which then stays set until reset. The current frame completes with correct data, and no extra frame is started for that edge.
- R10: The SCLK high phase and low phase each last HALF_DIV system clocks (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| drdy_ni | input | 1 | Converter data-ready, active low, asynchronous |
| demand_i | input | 1 | 1 selects on-demand mode (opcode before frame); sampled when a frame starts |
| miso_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter (opcode only) |
| status_o | output | 24 | Status word of the last completed frame |
| ch_data_o | output | 32 | Channel 1 in [31:16], channel 2 in [15:0], twos complement |
| valid_o | output | 1 | One-cycle strobe when a new frame is on the outputs |
| overrun_o | output | 1 | Sticky flag: data-ready fell during a frame |

## Verification
Several properties are checked on every cycle. SCLK stays low while chip select is high. Chip select stays low through the opcode and frame phases. Chip select rises exactly the guard length after the last SCLK fall, and the SCLK pulse count per frame matches the mode. The valid strobe coincides with the release of chip select, and the overrun flag never clears once set. Other behaviour can only be shown by the bench scenarios: that the right bits land in the right output fields for boundary codes, that the opcode byte reads correctly, that a held or rising data-ready starts nothing, and that an overrun edge leaves the current frame intact.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_FRAME = 2'd2,
    ST_GUARD = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_edge_det.sv
module adc_rd_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drdy_ni,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle level is high, so reset to ones to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], drdy_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             tick;

  assign tick = en_i && (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = ph_q;
  assign rise_o = tick & ~ph_q;
  assign fall_o = tick & ph_q;
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int           FRAME_W   = 56,
  parameter int           CMD_W     = 8,
  parameter logic [CMD_W-1:0] RD_OPCODE = 8'h12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               cmd_shift_i,
  input  logic               frame_shift_i,
  input  logic               miso_i,
  output logic               cmd_bit_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [CMD_W-1:0]   cmd_q;
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      frame_q <= '0;
    end else if (load_i) begin
      cmd_q   <= RD_OPCODE;
      frame_q <= '0;
    end else begin
      if (cmd_shift_i)   cmd_q   <= {cmd_q[CMD_W-2:0], 1'b0};
      if (frame_shift_i) frame_q <= {frame_q[FRAME_W-2:0], miso_i};
    end
  end

  assign cmd_bit_o = cmd_q[CMD_W-1];
  assign frame_o   = frame_q;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int               HALF_DIV     = 4,
  parameter int               GUARD_CYCLES = 10,
  parameter int               STATUS_W     = 24,
  parameter int               SAMPLE_W     = 16,
  parameter int               NUM_CH       = 2,
  parameter int               CMD_W        = 8,
  parameter logic [CMD_W-1:0] RD_OPCODE    = 8'h12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       drdy_ni,
  input  logic                       demand_i,
  input  logic                       miso_i,
  output logic                       cs_no,
  output logic                       sclk_o,
  output logic                       mosi_o,
  output logic [STATUS_W-1:0]        status_o,
  output logic [NUM_CH*SAMPLE_W-1:0] ch_data_o,
  output logic                       valid_o,
  output logic                       overrun_o
);
  localparam int CH_W    = NUM_CH * SAMPLE_W;
  localparam int FRAME_W = STATUS_W + CH_W;
  localparam int BIT_W   = $clog2(FRAME_W + CMD_W + 1);
  localparam int GRD_W   = $clog2(GUARD_CYCLES + 1);

  rd_state_e            state_q;
  logic [BIT_W-1:0]     bit_q;
  logic [GRD_W-1:0]     grd_q;
  logic                 cs_q, valid_q, ovr_q;
  logic [STATUS_W-1:0]  status_q;
  logic [CH_W-1:0]      ch_q;
  logic                 drdy_fall, sclk_en, sclk_rise, sclk_fall, cmd_bit;
  logic                 start;
  logic [FRAME_W-1:0]   frame;

  adc_rd_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drdy_ni(drdy_ni),
    .fall_o (drdy_fall)
  );

  assign sclk_en = (state_q == ST_CMD) || (state_q == ST_FRAME);
  assign start   = (state_q == ST_IDLE) && drdy_fall;

  adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sclk_en),
    .sclk_o(sclk_o),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  adc_rd_shifter #(
    .FRAME_W  (FRAME_W),
    .CMD_W    (CMD_W),
    .RD_OPCODE(RD_OPCODE)
  ) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start),
    .cmd_shift_i  ((state_q == ST_CMD) && sclk_fall),
    .frame_shift_i((state_q == ST_FRAME) && sclk_fall),
    .miso_i       (miso_i),
    .cmd_bit_o    (cmd_bit),
    .frame_o      (frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      grd_q    <= '0;
      cs_q     <= 1'b1;
      valid_q  <= 1'b0;
      ovr_q    <= 1'b0;
      status_q <= '0;
      ch_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      // edge seen while busy: flag it, drop it, keep reading
      if (drdy_fall && (state_q != ST_IDLE)) ovr_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (drdy_fall) begin
            cs_q    <= 1'b0;
            bit_q   <= '0;
            state_q <= demand_i ? ST_CMD : ST_FRAME;
          end
        end
        ST_CMD: begin
          if (sclk_fall) begin
            if (bit_q == BIT_W'(CMD_W - 1)) begin
              bit_q   <= '0;
              state_q <= ST_FRAME;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (sclk_fall) begin
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
              grd_q   <= '0;
              state_q <= ST_GUARD;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_GUARD: begin
          if (grd_q == GRD_W'(GUARD_CYCLES - 1)) begin
            state_q  <= ST_IDLE;
            cs_q     <= 1'b1;
            valid_q  <= 1'b1;
            status_q <= frame[FRAME_W-1 -: STATUS_W];
            ch_q     <= frame[CH_W-1:0];
          end else begin
            grd_q <= grd_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_q;
  assign mosi_o    = (state_q == ST_CMD) & cmd_bit;
  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;
  assign status_o  = status_q;
  assign ch_data_o = ch_q;

  // checker state
  logic [GRD_W:0]   since_fall_q;
  logic [BIT_W-1:0] rise_cnt_q;
  logic             mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_fall_q <= '0;
      rise_cnt_q   <= '0;
      mode_q       <= 1'b0;
    end else begin
      if (sclk_fall) since_fall_q <= '0;
      else if (since_fall_q != '1) since_fall_q <= since_fall_q + 1'b1;
      if (start) begin
        rise_cnt_q <= '0;
        mode_q     <= demand_i;
      end else if (sclk_rise) begin
        rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_cs_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en |-> !cs_no);

  assert_pulse_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_cnt_q == (mode_q ? BIT_W'(FRAME_W + CMD_W) : BIT_W'(FRAME_W))));

  assert_guard_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (since_fall_q == (GRD_W+1)'(GUARD_CYCLES)));

  assert_valid_at_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !$past(cs_no)));

  assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  localparam int HALF  = 4;
  localparam int GUARD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drdy_n = 1'b1;
  logic        demand = 1'b0;
  logic        miso;
  logic        cs_n, sclk, mosi, valid, ovr;
  logic [23:0] status;
  logic [31:0] ch_data;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF), .GUARD_CYCLES(GUARD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .drdy_ni(drdy_n), .demand_i(demand),
    .miso_i(miso), .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi),
    .status_o(status), .ch_data_o(ch_data), .valid_o(valid), .overrun_o(ovr)
  );

  // {demand, status, ch1, ch2}
  localparam int NV = 6;
  localparam logic [56:0] VECS [NV] = '{
    {1'b0, 24'hC00000, 16'h7FFF, 16'h8000},
    {1'b0, 24'h123456, 16'h0001, 16'hFFFF},
    {1'b1, 24'hC0A5F0, 16'h8000, 16'h7FFF},
    {1'b1, 24'h000000, 16'h0000, 16'h0000},
    {1'b0, 24'hFFFFFF, 16'hFFFF, 16'hFFFF},
    {1'b1, 24'h5A5A5A, 16'h1234, 16'hEDCB}
  };

  int total = 0, failed = 0;
  bit done = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // converter model
  logic [55:0] cur_frame = '0;
  logic [55:0] dev_sr = '0;
  logic        p_cs = 1'bx, p_sclk = 1'bx;
  int rises = 0, falls = 0, mosi_bad = 0, cs_rises = 0, cs_falls = 0;
  int rise_cyc = 0, fall_cyc = 0, cs_rise_cyc = 0;
  int hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
  logic [7:0] cmd_cap = '0;

  assign miso = dev_sr[55];

  always @(cs_n or sclk) begin
    if (cs_n !== p_cs) begin
      if (cs_n === 1'b0) begin
        dev_sr = cur_frame; rises = 0; falls = 0; cmd_cap = '0; cs_falls++;
      end else if (cs_n === 1'b1) begin
        cs_rise_cyc = cyc; cs_rises++;
      end
    end
    if (sclk !== p_sclk) begin
      if (sclk === 1'b1) begin
        rises++;
        if (rises > 1) begin
          if (cyc - fall_cyc < lo_min) lo_min = cyc - fall_cyc;
          if (cyc - fall_cyc > lo_max) lo_max = cyc - fall_cyc;
        end
        rise_cyc = cyc;
        if (demand && rises <= 8) cmd_cap = {cmd_cap[6:0], mosi};
        else if (mosi !== 1'b0) mosi_bad++;
      end else if (sclk === 1'b0 && p_sclk === 1'b1) begin
        falls++;
        if (!(demand && falls <= 8)) dev_sr = {dev_sr[54:0], 1'b0};
        if (cyc - rise_cyc < hi_min) hi_min = cyc - rise_cyc;
        if (cyc - rise_cyc > hi_max) hi_max = cyc - rise_cyc;
        fall_cyc = cyc;
      end
    end
    p_cs = cs_n; p_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic pulse_drdy();
    @(negedge clk) drdy_n = 1'b0;
    repeat (6) @(negedge clk);
    drdy_n = 1'b1;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (valid) begin got = 1; break; end
    end
  endtask

  task automatic run_frame(input logic [56:0] v, input bit expect_ovr_edge);
    bit got;
    logic [23:0] st;
    logic [31:0] cd;
    logic cs_at;
    demand = v[56];
    cur_frame = v[55:0];
    pulse_drdy();
    if (expect_ovr_edge) begin
      repeat (150) @(negedge clk);
      pulse_drdy();
    end
    wait_valid(got);
    chk(got, "R2 frame completes", 64'(got), 64'd1);
    st = status; cd = ch_data; cs_at = cs_n;
    chk(st == v[55:32], "R4 status word", 64'(st), 64'(v[55:32]));
    chk(cd[31:16] == v[31:16], "R4 channel 1", 64'(cd[31:16]), 64'(v[31:16]));
    chk(cd[15:0] == v[15:0], "R4 channel 2", 64'(cd[15:0]), 64'(v[15:0]));
    chk(cs_at == 1'b1, "R8 cs high with valid", 64'(cs_at), 64'd1);
    if (v[56]) begin
      chk(rises == 64, "R5 pulse count on-demand", 64'(rises), 64'd64);
      chk(cmd_cap == 8'h12, "R5 opcode byte", 64'(cmd_cap), 64'h12);
    end else begin
      chk(rises == 56, "R3 pulse count continuous", 64'(rises), 64'd56);
    end
    chk(cs_rise_cyc - fall_cyc == GUARD, "R7 guard length", 64'(cs_rise_cyc - fall_cyc), 64'(GUARD));
    chk(mosi_bad == 0, "R6 mosi quiet in frame", 64'(mosi_bad), 64'd0);
    @(negedge clk);
    chk(valid == 1'b0, "R8 valid one cycle", 64'(valid), 64'd0);
    repeat (20) @(negedge clk);
    chk(status == st && ch_data == cd, "R8 outputs hold", {8'h0, status, ch_data}, {8'h0, st, cd});
    chk(mosi == 1'b0, "R6 mosi idle low", 64'(mosi), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int f0;
    bit got;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && valid == 0 && ovr == 0, "R1 reset state",
        {59'h0, cs_n, sclk, mosi, valid, ovr}, 64'h10);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(cs_n == 1'b1, "R2 no frame without edge", 64'(cs_n), 64'd1);
    chk(ovr == 1'b0, "R9 overrun clear initially", 64'(ovr), 64'd0);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);
    chk(hi_min == HALF && hi_max == HALF, "R10 sclk high phase", 64'(hi_max), 64'(HALF));
    chk(lo_min == HALF && lo_max == HALF, "R10 sclk low phase", 64'(lo_max), 64'(HALF));

    // R2: held-low data-ready gives one frame, rising edge gives none
    f0 = cs_falls;
    demand = 1'b0;
    cur_frame = {24'hABCDEF, 16'h0F0F, 16'hF0F0};
    @(negedge clk) drdy_n = 1'b0;
    wait_valid(got);
    repeat (200) @(negedge clk);
    chk(cs_falls - f0 == 1, "R2 held low one frame", 64'(cs_falls - f0), 64'd1);
    drdy_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(cs_falls - f0 == 1 && cs_n == 1'b1, "R2 rising edge ignored", 64'(cs_falls - f0), 64'd1);
    chk(ovr == 1'b0, "R9 no overrun on idle edges", 64'(ovr), 64'd0);

    // R9: overrun edge mid-frame
    f0 = cs_falls;
    run_frame({1'b0, 24'h3C3C3C, 16'h8001, 16'h7FFE}, 1'b1);
    chk(ovr == 1'b1, "R9 overrun set", 64'(ovr), 64'd1);
    repeat (300) @(negedge clk);
    chk(cs_falls - f0 == 1, "R9 no extra frame", 64'(cs_falls - f0), 64'd1);
    run_frame({1'b1, 24'h0A0B0C, 16'h4000, 16'hC000}, 1'b0);
    chk(ovr == 1'b1, "R9 overrun sticky", 64'(ovr), 64'd1);

    // R1: reset mid-frame
    demand = 1'b0;
    cur_frame = {24'h111111, 16'h2222, 16'h3333};
    pulse_drdy();
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && valid == 0 && ovr == 0, "R1 reset mid-frame",
        {59'h0, cs_n, sclk, mosi, valid, ovr}, 64'h10);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    run_frame({1'b0, 24'h800000, 16'h0001, 16'h8000}, 1'b0);

    done = 1;
    finish_run();
  end
endmodule